// File: doc/BRIEF.md
# Always-On Match Timer

This block is a free-running timer meant to sit in an always-on power domain. Software controls it through a small 32-bit register bus. One command bit lets it run or stops it, and while stopped the count is held. The count advances once every N system clock cycles, where N is a programmable divider. A separate command bit returns the count to zero and clears the match flag.

Software also programs an end value. When the count steps onto that value, a sticky match flag is set. The flag is driven straight out as a level event toward an external interrupt controller, where it can act as a wake or interrupt source. The timer has no enable of its own for the event. The counter keeps running after a match and wraps at its full width, so a match recurs only after a full wrap unless software reprograms the end value or issues a clear.

Top module: `aon_match_timer`

## Requirements
- R1: After reset the count reads 0, the status register reads 0, the command register reads 0 and `match_evt_o` is low.
- R2: Command bit 0 is the run control. Writing 1 makes the count advance. Writing 0 stops it, and the count then holds its value until run is written to 1 again.
- R3: Writing a command word with bit 1 set zeroes the count, clears the match flag and restarts the prescaler, whether the timer is running or stopped. If bit 0 and bit 1 are written together, the first increment comes one full divider period after the write.
- R4: With divider value d ≥ 1, the count equals floor(n/d) at n clock edges after a combined clear-and-run command, while no wrap occurs.
- R5: A divider value of 0 behaves exactly like a divider value of 1.
- R6: The match flag is set on the increment that makes the count equal to the end value. It stays set until a clear command. The counter keeps counting past the match and wraps to 0 after 2^COUNT_W − 1.
- R7: `match_evt_o` is high exactly when the match flag is set, and no other enable gates it.
- R8: The count and status registers are read-only, and writes to them have no effect. The status register reads the match flag in bit 0 and zeros in bits 31:1. The command register reads the run bit in bit 0, and bit 1 always reads 0.
- R9: The register offsets are 0x6C command, 0x70 end value, 0x74 divider, 0x78 count and 0x7C status. The end value and divider registers read back the value last written. Reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte offset of the register accessed |
| reg_we | input | 1 | Write strobe; the write takes effect at the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the register at `reg_addr` |
| match_evt_o | output | 1 | Level event to the interrupt controller, high while the match flag is set |

## Verification
The hardest case to reach from the ports is the counter wrap. At the default 32-bit width it would take billions of cycles. The bench therefore builds a second copy of the timer with a 4-bit count, drives both copies from the same bus, and runs the narrow copy past 15 and back through zero while its match flag stays set. The other hard case is a clear-and-run command that lands partway through a divider period. Each table vector issues that command over the remains of the previous vector's prescaler phase, so a leftover phase would show up as an early first increment.

// File: rtl/aon_tmr_pkg.sv
package aon_tmr_pkg;

   localparam int BUS_W = 32;

   // byte offsets decoded by software drivers
   localparam logic [7:0] OFS_CMD  = 8'h6C;
   localparam logic [7:0] OFS_END  = 8'h70;
   localparam logic [7:0] OFS_DIV  = 8'h74;
   localparam logic [7:0] OFS_CNT  = 8'h78;
   localparam logic [7:0] OFS_STAT = 8'h7C;

   localparam int CMD_RUN_BIT = 0;
   localparam int CMD_CLR_BIT = 1;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CMD,
      SEL_END,
      SEL_DIV,
      SEL_CNT,
      SEL_STAT
   } reg_sel_e;

endpackage

// File: rtl/aon_tmr_regs.sv
module aon_tmr_regs
   import aon_tmr_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int COUNT_W = 32,
   parameter int DIV_W   = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_we,
   input  logic [BUS_W-1:0]   reg_wdata,
   output logic [BUS_W-1:0]   reg_rdata,
   input  logic [COUNT_W-1:0] cnt_i,
   input  logic               flag_i,
   output logic               run_o,
   output logic               clr_o,
   output logic [COUNT_W-1:0] end_o,
   output logic [DIV_W-1:0]   div_o
);

   reg_sel_e            sel;
   logic                run_q;
   logic [COUNT_W-1:0]  end_q;
   logic [DIV_W-1:0]    div_q;
   logic                wr_cmd;

   always_comb begin
      sel = SEL_NONE;
      if (reg_addr == ADDR_W'(OFS_CMD))  sel = SEL_CMD;
      if (reg_addr == ADDR_W'(OFS_END))  sel = SEL_END;
      if (reg_addr == ADDR_W'(OFS_DIV))  sel = SEL_DIV;
      if (reg_addr == ADDR_W'(OFS_CNT))  sel = SEL_CNT;
      if (reg_addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
   end

   assign wr_cmd = reg_we && (sel == SEL_CMD);
   // clear is a single-cycle strobe, never stored
   assign clr_o  = wr_cmd && reg_wdata[CMD_CLR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         end_q <= '0;
         div_q <= '0;
      end else begin
         if (wr_cmd)
            run_q <= reg_wdata[CMD_RUN_BIT];
         if (reg_we && (sel == SEL_END))
            end_q <= reg_wdata[COUNT_W-1:0];
         if (reg_we && (sel == SEL_DIV))
            div_q <= reg_wdata[DIV_W-1:0];
      end
   end

   always_comb begin
      case (sel)
         SEL_CMD:  reg_rdata = BUS_W'(run_q);
         SEL_END:  reg_rdata = BUS_W'(end_q);
         SEL_DIV:  reg_rdata = BUS_W'(div_q);
         SEL_CNT:  reg_rdata = BUS_W'(cnt_i);
         SEL_STAT: reg_rdata = BUS_W'(flag_i);
         default:  reg_rdata = '0;
      endcase
   end

   assign run_o = run_q;
   assign end_o = end_q;
   assign div_o = div_q;

endmodule

// File: rtl/aon_tmr_prescaler.sv
module aon_tmr_prescaler #(
   parameter int DIV_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             clr_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] pre_q;
   logic [DIV_W-1:0] div_eff;
   logic [DIV_W-1:0] limit;
   logic             at_limit;

   // zero divider folds onto one
   assign div_eff  = (div_i == '0) ? DIV_W'(1) : div_i;
   assign limit    = div_eff - DIV_W'(1);
   // >= keeps a shrunk divider from stalling a phase already past it
   assign at_limit = (pre_q >= limit);
   assign tick_o   = run_i && !clr_i && at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (clr_i)
         pre_q <= '0;
      else if (run_i)
         pre_q <= at_limit ? '0 : pre_q + DIV_W'(1);
   end

endmodule

// File: rtl/aon_tmr_counter.sv
module aon_tmr_counter #(
   parameter int COUNT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_i,
   input  logic               tick_i,
   input  logic [COUNT_W-1:0] end_i,
   output logic [COUNT_W-1:0] cnt_o,
   output logic               flag_o
);

   logic [COUNT_W-1:0] cnt_q;
   logic [COUNT_W-1:0] cnt_nxt;
   logic               flag_q;
   logic               hit;

   assign cnt_nxt = cnt_q + COUNT_W'(1);   // natural wrap at full width
   assign hit     = tick_i && (cnt_nxt == end_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else if (clr_i) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (tick_i) cnt_q  <= cnt_nxt;
         if (hit)    flag_q <= 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign flag_o = flag_q;

endmodule

// File: rtl/aon_match_timer.sv
module aon_match_timer
   import aon_tmr_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int COUNT_W = 32,
   parameter int DIV_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   output logic              match_evt_o
);

   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must cover the 8-bit register offsets");
   end
   if (COUNT_W < 1 || COUNT_W > BUS_W) begin : g_bad_cnt
      $error("COUNT_W must lie in 1..32");
   end
   if (DIV_W < 1 || DIV_W > BUS_W) begin : g_bad_div
      $error("DIV_W must lie in 1..32");
   end

   logic               run_w;
   logic               clr_w;
   logic               tick_w;
   logic               flag_w;
   logic [COUNT_W-1:0] cnt_w;
   logic [COUNT_W-1:0] end_w;
   logic [DIV_W-1:0]   div_w;

   aon_tmr_regs #(
      .ADDR_W  (ADDR_W),
      .COUNT_W (COUNT_W),
      .DIV_W   (DIV_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .cnt_i     (cnt_w),
      .flag_i    (flag_w),
      .run_o     (run_w),
      .clr_o     (clr_w),
      .end_o     (end_w),
      .div_o     (div_w)
   );

   aon_tmr_prescaler #(
      .DIV_W (DIV_W)
   ) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run_w),
      .clr_i  (clr_w),
      .div_i  (div_w),
      .tick_o (tick_w)
   );

   aon_tmr_counter #(
      .COUNT_W (COUNT_W)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_w),
      .tick_i (tick_w),
      .end_i  (end_w),
      .cnt_o  (cnt_w),
      .flag_o (flag_w)
   );

   assign match_evt_o = flag_w;

endmodule

// File: rtl/aon_tmr_checker.sv
module aon_tmr_checker
   import aon_tmr_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int COUNT_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_we,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic               clr_bit,
   input logic [BUS_W-1:0]   reg_rdata,
   input logic               run_q,
   input logic [COUNT_W-1:0] cnt,
   input logic [COUNT_W-1:0] end_v,
   input logic               evt
);

   logic clr_wr;
   assign clr_wr = reg_we && (reg_addr == ADDR_W'(OFS_CMD)) && clr_bit;

   AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> (cnt == '0) && !evt);                                  // R3

   AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !clr_wr) |=> $stable(cnt));                             // R2

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + COUNT_W'(1)));  // R4

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !clr_wr) |=> evt);                                         // R6

   AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt) |-> (cnt == $past(end_v)));                             // R6

   AST_STAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFS_STAT)) |-> (reg_rdata == BUS_W'(evt)));  // R7

endmodule

bind aon_match_timer aon_tmr_checker #(
   .ADDR_W  (ADDR_W),
   .COUNT_W (COUNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .clr_bit   (reg_wdata[1]),
   .reg_rdata (reg_rdata),
   .run_q     (run_w),
   .cnt       (cnt_w),
   .end_v     (end_w),
   .evt       (match_evt_o)
);

// File: tb/tb_aon_match_timer.sv
module tb_aon_match_timer;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 10;

   typedef struct packed {
      logic [31:0] div;
      logic [31:0] endv;
      logic [31:0] n;
      logic [31:0] exp_cnt;
      logic        exp_flag;
   } vec_t;

   // count after n edges = floor(n/d); flag once that reaches end (R4, R5, R6)
   localparam vec_t VECS [NVEC] = '{
      '{32'd1, 32'd5,  32'd3,  32'd3,  1'b0},
      '{32'd1, 32'd5,  32'd5,  32'd5,  1'b1},
      '{32'd1, 32'd5,  32'd9,  32'd9,  1'b1},
      '{32'd4, 32'd3,  32'd11, 32'd2,  1'b0},
      '{32'd4, 32'd3,  32'd12, 32'd3,  1'b1},
      '{32'd0, 32'd2,  32'd2,  32'd2,  1'b1},
      '{32'd3, 32'd10, 32'd30, 32'd10, 1'b1},
      '{32'd7, 32'd1,  32'd6,  32'd0,  1'b0},
      '{32'd7, 32'd1,  32'd7,  32'd1,  1'b1},
      '{32'd2, 32'd4,  32'd7,  32'd3,  1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] rdata, rdata_w;
   logic        evt, evt_w;

   int nchk = 0;
   int nfail = 0;
   logic [31:0] held;

   always #(CLK_PERIOD/2) clk = ~clk;

   aon_match_timer dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(rdata), .match_evt_o(evt)
   );

   aon_match_timer #(.COUNT_W(4)) dut_w (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(rdata_w), .match_evt_o(evt_w)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] dw);
      reg_addr = a;
      #1;
      d = rdata; dw = rdata_w;
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [31:0] d, dw;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h78, d, dw); check("R1 count", d, 32'h0);
      rd(8'h7C, d, dw); check("R1 status", d, 32'h0);
      rd(8'h6C, d, dw); check("R1 command", d, 32'h0);
      check("R1 event", {31'b0, evt}, 32'h0);

      // table walk: clear+run lands over the previous vector's prescaler phase (R3, R4)
      for (int i = 0; i < NVEC; i++) begin
         wr(8'h74, VECS[i].div);
         wr(8'h70, VECS[i].endv);
         wr(8'h6C, 32'h3);
         edges(int'(VECS[i].n));
         rd(8'h78, d, dw); check("R4 count vs floor(n/d)", d, VECS[i].exp_cnt);
         rd(8'h7C, d, dw); check("R6 status after run", d, {31'b0, VECS[i].exp_flag});
         check("R7 event equals flag", {31'b0, evt}, {31'b0, VECS[i].exp_flag});
      end

      // R3 clear+run mid-period restarts prescaler: first step a full period later
      wr(8'h74, 32'd4);
      wr(8'h70, 32'd100);
      wr(8'h6C, 32'h1);
      edges(6);
      wr(8'h6C, 32'h3);
      edges(3);
      rd(8'h78, d, dw); check("R3 no early step", d, 32'd0);
      edges(1);
      rd(8'h78, d, dw); check("R3 step after full period", d, 32'd1);

      // R9 readback of end and divider
      wr(8'h70, 32'hDEADBEEF);
      rd(8'h70, d, dw); check("R9 end readback", d, 32'hDEADBEEF);
      wr(8'h74, 32'h00000012);
      rd(8'h74, d, dw); check("R9 divider readback", d, 32'h12);

      // R6 wrap: narrow copy runs past 15 while flag stays set
      wr(8'h74, 32'd1);
      wr(8'h70, 32'd2);
      wr(8'h6C, 32'h3);
      edges(20);
      rd(8'h78, d, dw);
      check("R6 wide count keeps running", d, 32'd20);
      check("R6 narrow count wrapped", dw, 32'd4);
      rd(8'h7C, d, dw);
      check("R6 wide flag sticky", d, 32'd1);
      check("R6 narrow flag sticky", dw, 32'd1);

      // R2 stop holds count
      wr(8'h6C, 32'h0);
      rd(8'h78, held, dw);
      edges(10);
      rd(8'h78, d, dw); check("R2 count held while stopped", d, held);

      // R8 writes to count and status ignored
      wr(8'h78, 32'h00000055);
      wr(8'h7C, 32'h00000000);
      rd(8'h78, d, dw); check("R8 count write ignored", d, held);
      rd(8'h7C, d, dw); check("R8 status write ignored", d, 32'd1);
      rd(8'h6C, d, dw); check("R8 command reads run only", d, 32'd0);

      // R2 restart continues from held value
      wr(8'h6C, 32'h1);
      edges(3);
      rd(8'h78, d, dw); check("R2 resume from held", d, held + 32'd3);
      rd(8'h6C, d, dw); check("R8 command reads run bit", d, 32'd1);

      // R3 clear while stopped
      wr(8'h6C, 32'h0);
      wr(8'h6C, 32'h2);
      rd(8'h78, d, dw); check("R3 clear zeroes count", d, 32'd0);
      rd(8'h7C, d, dw); check("R3 clear drops flag", d, 32'd0);
      check("R7 event low after clear", {31'b0, evt}, 32'd0);
      edges(5);
      rd(8'h78, d, dw); check("R3 clear alone does not run", d, 32'd0);

      summary();
   end

endmodule